// File: doc/BRIEF.md
# Split-Permission Address Translation Cache

This block caches virtual-to-physical page mappings for a processor pipeline. It is direct-mapped. Each slot keeps the physical page number once, in a shared data array. It also keeps three separate tag copies of the virtual page number, one for instruction fetch, one for loads and one for stores. A lookup compares the virtual page number against all three tag copies for the selected slot at once. A hit is reported for the requested access kind, and a miss asks the surrounding logic to walk the page tables and refill.

A refill presents the page table entry that the walker returned, together with the access kind and the current privilege level. The block checks permissions for that one access. A failed check raises an access fault of the matching kind and installs nothing. A passed check writes each tag copy with the virtual page number only if the entry grants that kind of access, so later permission failures appear as ordinary misses. A flush input empties every slot. A no-cache input lets a refill return its translation without changing the stored state.

Top module: `xlat_buf`

## Requirements
- R1: The slot index is the low log2(ENTRIES) bits of the virtual page number, `vaddr >> PAGE_SHIFT`. ENTRIES is a power of two. Each tag holds the full virtual page number, so a second page that maps to the same slot evicts the first.
- R2: After reset, and in the cycle after `flush_i` is high, every hit output is low for any address whose virtual page number is not all ones. The all-ones value is reserved as the empty marker.
- R3: An accepted refill installs its page in the fetch tag only when the effective execute bit is set, in the load tag only when the effective read bit is set, and in the store tag only when the effective write bit is set. The other tag copies of that slot are emptied.
- R4: The entry bits are: valid at bit 0, user execute/write/read at bits 2/3/4, and supervisor execute/write/read at bits 5/6/7. With `rf_sup_i` high, the supervisor bits are used in place of the user bits. With `rf_sup_i` low, the user bits are used.
- R5: A refill faults when the entry's valid bit or the effective permission bit required for its kind is clear. A faulting refill installs nothing.
- R6: Access kind codes are 0 for fetch, 1 for load, 2 for store, and 3, which is treated as a load. On a fault, `rf_fault_kind_o` carries the kind code (0 for instruction, 2 for store, 1 otherwise) and `rf_fault_addr_o` carries the refill virtual address.
- R7: The physical address is the entry's bits above PAGE_SHIFT followed by the page offset of the virtual address. This holds both for the refill output and for the lookup output on a hit.
- R8: A refill with `rf_nocache_i` high still returns its physical address and fault status, but leaves every tag and data slot unchanged.
- R9: When `flush_i` and a refill occur in the same cycle, the flush wins and nothing is installed.
- R10: Lookup is combinational. `lk_hits_o` bits 0/1/2 report the fetch/load/store tag matches, `lk_hit_o` is the match for the requested kind, and `lk_miss_o` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty every slot at the clock edge |
| lk_vaddr_i | input | VA_W | Lookup virtual address |
| lk_kind_i | input | 2 | Lookup access kind |
| lk_hits_o | output | 3 | Per-kind tag match {store, load, fetch} |
| lk_hit_o | output | 1 | Match for the requested kind |
| lk_miss_o | output | 1 | Refill request for the requested kind |
| lk_paddr_o | output | PTE_W | Lookup physical address |
| rf_valid_i | input | 1 | Refill strobe |
| rf_vaddr_i | input | VA_W | Refill virtual address |
| rf_kind_i | input | 2 | Refill access kind |
| rf_pte_i | input | PTE_W | Page table entry from the walker |
| rf_sup_i | input | 1 | Supervisor privilege |
| rf_nocache_i | input | 1 | Translate without installing |
| rf_paddr_o | output | PTE_W | Refill physical address |
| rf_fault_o | output | 1 | Access fault |
| rf_fault_kind_o | output | 2 | Fault kind code |
| rf_fault_addr_o | output | VA_W | Faulting virtual address |

## Verification
The assertions assume that no refill or lookup uses a virtual page number of all ones, because that value marks an empty tag. They also assume that the refill inputs are stable around the clock edge. The bench keeps every page number small and distinct from the marker, and it drives all inputs half a cycle away from the active edge. Its permission sweep covers every combination of the six permission bits, the valid bit, the privilege level and the three access kinds.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_LOAD  = 2'd1;
  localparam logic [1:0] KIND_STORE = 2'd2;

  localparam int BIT_V   = 0;
  localparam int BIT_UX  = 2;
  localparam int BIT_UW  = 3;
  localparam int BIT_UR  = 4;
  localparam int SUP_SHIFT = 3;
  localparam logic [7:0] PERM_MASK = 8'b0001_1100;

  function automatic logic [1:0] norm_kind(input logic [1:0] k);
    return (k == 2'd3) ? KIND_LOAD : k;
  endfunction
endpackage

// File: rtl/xlat_perm_check.sv
module xlat_perm_check
  import xlat_pkg::*;
(
  input  logic [7:0] pte_lo_i,
  input  logic       sup_i,
  input  logic [1:0] kind_i,
  output logic [2:0] grant_o,   // {store, load, fetch}
  output logic       fault_o
);
  logic [7:0] eff;
  logic       need;

  always_comb begin
    eff = sup_i ? ((pte_lo_i >> SUP_SHIFT) & PERM_MASK) : (pte_lo_i & PERM_MASK);
    eff[BIT_V] = pte_lo_i[BIT_V];
    grant_o = {eff[BIT_UW], eff[BIT_UR], eff[BIT_UX]};
    unique case (kind_i)
      KIND_FETCH: need = eff[BIT_UX];
      KIND_STORE: need = eff[BIT_UW];
      default:    need = eff[BIT_UR];
    endcase
    fault_o = !(need && eff[BIT_V]);
  end
endmodule

// File: rtl/xlat_tag_array.sv
module xlat_tag_array #(
  parameter int ENTRIES = 256,
  parameter int TAG_W   = 52,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             hit_o
);
  logic [TAG_W-1:0] tag_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '1;
    end else if (clr_i) begin
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '1;
    end else if (wr_i) begin
      tag_q[wr_idx_i] <= wr_tag_i;
    end
  end

  assign hit_o = (tag_q[rd_idx_i] == rd_tag_i);

  assert_clear_empties_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (hit_o == (rd_tag_i == '1)));
endmodule

// File: rtl/xlat_data_array.sv
module xlat_data_array #(
  parameter int ENTRIES = 256,
  parameter int PPN_W   = 52,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [PPN_W-1:0] rd_ppn_o
);
  logic [PPN_W-1:0] ppn_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) ppn_q[i] <= '0;
    end else if (wr_i) begin
      ppn_q[wr_idx_i] <= wr_ppn_i;
    end
  end

  assign rd_ppn_o = ppn_q[rd_idx_i];
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
  import xlat_pkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRIES    = 256,
  parameter int VA_W       = 64,
  parameter int PTE_W      = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [VA_W-1:0]   lk_vaddr_i,
  input  logic [1:0]        lk_kind_i,
  output logic [2:0]        lk_hits_o,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic [PTE_W-1:0]  lk_paddr_o,
  input  logic              rf_valid_i,
  input  logic [VA_W-1:0]   rf_vaddr_i,
  input  logic [1:0]        rf_kind_i,
  input  logic [PTE_W-1:0]  rf_pte_i,
  input  logic              rf_sup_i,
  input  logic              rf_nocache_i,
  output logic [PTE_W-1:0]  rf_paddr_o,
  output logic              rf_fault_o,
  output logic [1:0]        rf_fault_kind_o,
  output logic [VA_W-1:0]   rf_fault_addr_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int VPN_W = VA_W - PAGE_SHIFT;
  localparam int PPN_W = PTE_W - PAGE_SHIFT;

  logic [VPN_W-1:0] lk_vpn, rf_vpn;
  logic [IDX_W-1:0] lk_idx, rf_idx;
  logic [2:0]       grant;
  logic             perm_fault;
  logic             install;
  logic [PPN_W-1:0] lk_ppn;
  logic             unused_pte;

  assign lk_vpn = lk_vaddr_i[VA_W-1:PAGE_SHIFT];
  assign rf_vpn = rf_vaddr_i[VA_W-1:PAGE_SHIFT];
  assign lk_idx = lk_vpn[IDX_W-1:0];
  assign rf_idx = rf_vpn[IDX_W-1:0];
  assign unused_pte = ^rf_pte_i[PAGE_SHIFT-1:8] ^ rf_pte_i[1];

  xlat_perm_check u_perm (
    .pte_lo_i (rf_pte_i[7:0]),
    .sup_i    (rf_sup_i),
    .kind_i   (rf_kind_i),
    .grant_o  (grant),
    .fault_o  (perm_fault)
  );

  assign install = rf_valid_i && !perm_fault && !rf_nocache_i && !flush_i;

  for (genvar g = 0; g < 3; g++) begin : g_tags
    xlat_tag_array #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_tags (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (flush_i),
      .wr_i     (install),
      .wr_idx_i (rf_idx),
      .wr_tag_i (grant[g] ? rf_vpn : {VPN_W{1'b1}}),
      .rd_idx_i (lk_idx),
      .rd_tag_i (lk_vpn),
      .hit_o    (lk_hits_o[g])
    );
  end

  xlat_data_array #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_data (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (install),
    .wr_idx_i (rf_idx),
    .wr_ppn_i (rf_pte_i[PTE_W-1:PAGE_SHIFT]),
    .rd_idx_i (lk_idx),
    .rd_ppn_o (lk_ppn)
  );

  assign lk_hit_o   = lk_hits_o[norm_kind(lk_kind_i)];
  assign lk_miss_o  = !lk_hit_o;
  assign lk_paddr_o = {lk_ppn, lk_vaddr_i[PAGE_SHIFT-1:0]};

  assign rf_paddr_o      = {rf_pte_i[PTE_W-1:PAGE_SHIFT], rf_vaddr_i[PAGE_SHIFT-1:0]};
  assign rf_fault_o      = rf_valid_i && perm_fault;
  assign rf_fault_kind_o = norm_kind(rf_kind_i);
  assign rf_fault_addr_o = rf_vaddr_i;

  assert_fault_blocks_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_fault_o |-> !install);
  assert_fault_report_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_fault_o |-> (rf_fault_addr_o == rf_vaddr_i && rf_fault_kind_o != 2'd3));
  assert_invalid_faults_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_valid_i && !rf_pte_i[BIT_V]) |-> rf_fault_o);
  assert_offset_passthru_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (lk_paddr_o[PAGE_SHIFT-1:0] == lk_vaddr_i[PAGE_SHIFT-1:0]));
  assert_flush_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (lk_hits_o == 3'b000 || lk_vpn == '1));
  assert_miss_inverse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_miss_o != lk_hit_o);
endmodule

// File: tb/xlat_buf_bench.sv
module xlat_buf_bench;
  localparam int PS = 12;
  localparam int NE = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        flush = 0;
  logic [63:0] lk_va = '0;
  logic [1:0]  lk_kind = '0;
  logic [2:0]  lk_hits;
  logic        lk_hit, lk_miss;
  logic [63:0] lk_pa;
  logic        rf_v = 0;
  logic [63:0] rf_va = '0;
  logic [1:0]  rf_kind = '0;
  logic [63:0] rf_pte = '0;
  logic        rf_sup = 0, rf_nc = 0;
  logic [63:0] rf_pa;
  logic        rf_fault;
  logic [1:0]  rf_fkind;
  logic [63:0] rf_faddr;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  xlat_buf #(.PAGE_SHIFT(PS), .ENTRIES(NE)) u_xlat_buf (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .lk_vaddr_i(lk_va), .lk_kind_i(lk_kind), .lk_hits_o(lk_hits),
    .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_paddr_o(lk_pa),
    .rf_valid_i(rf_v), .rf_vaddr_i(rf_va), .rf_kind_i(rf_kind),
    .rf_pte_i(rf_pte), .rf_sup_i(rf_sup), .rf_nocache_i(rf_nc),
    .rf_paddr_o(rf_pa), .rf_fault_o(rf_fault), .rf_fault_kind_o(rf_fkind),
    .rf_fault_addr_o(rf_faddr));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_va(input logic [51:0] vpn, input logic [11:0] off);
    return {vpn, off};
  endfunction

  function automatic logic [63:0] mk_pte(input logic [51:0] ppn, input logic [5:0] perm, input bit v);
    return {ppn, 4'b0, perm, 1'b0, v};
  endfunction

  // drive a refill for one cycle; comb outputs sampled mid-cycle, write at the next posedge
  task automatic refill(input logic [63:0] va, input logic [1:0] k, input logic [63:0] pte,
                        input bit sup, input bit nc, input bit fl);
    @(negedge clk);
    rf_v = 1; rf_va = va; rf_kind = k; rf_pte = pte; rf_sup = sup; rf_nc = nc; flush = fl;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    rf_v = 0; rf_nc = 0; flush = 0;
  endtask

  task automatic look(input logic [63:0] va, input logic [1:0] k);
    lk_va = va; lk_kind = k;
    #1;
  endtask

  initial begin
    #(10 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2: empty after reset
    for (int v = 0; v < 2 * NE; v++) begin
      look(mk_va(52'(v), 12'h0), 2'd1);
      check(lk_hits == 3'b000 && lk_miss, "R2 reset empty", {61'd0, lk_hits}, 64'd0);
    end

    // R3 R4 R5 R6 R7 R10: permission sweep
    for (int perm = 0; perm < 64; perm++)
      for (int v = 0; v < 2; v++)
        for (int sup = 0; sup < 2; sup++)
          for (int k = 0; k < 3; k++) begin
            logic [5:0]  p6 = 6'(perm);
            logic [2:0]  eff;
            logic        need, fexp;
            logic [51:0] vpn = 52'(cnt + 16);
            logic [51:0] ppn = 52'(cnt * 3 + 5);
            logic [11:0] off = 12'(cnt * 37);
            logic [63:0] va = mk_va(vpn, off);
            eff = sup ? {p6[4], p6[5], p6[3]} : {p6[1], p6[2], p6[0]}; // {w,r,x}
            need = (k == 0) ? eff[0] : (k == 2) ? eff[2] : eff[1];
            fexp = !(need && v == 1);
            refill(va, 2'(k), mk_pte(ppn, p6, v[0]), sup[0], 0, 0);
            check(rf_fault == fexp, "R5 fault", {63'd0, rf_fault}, {63'd0, fexp});
            check(rf_pa == {ppn, off}, "R7 refill paddr", rf_pa, {ppn, off});
            if (fexp)
              check(rf_fkind == 2'(k) && rf_faddr == va, "R6 fault kind/addr",
                    {rf_fkind, rf_faddr[61:0]}, {2'(k), va[61:0]});
            idle();
            look(va, 2'(k));
            check(lk_hits == (fexp ? 3'b000 : eff), "R3 R4 hit vector",
                  {61'd0, lk_hits}, {61'd0, (fexp ? 3'b000 : eff)});
            check(lk_miss == fexp, "R10 miss", {63'd0, lk_miss}, {63'd0, fexp});
            if (!fexp) check(lk_pa == {ppn, off}, "R7 lookup paddr", lk_pa, {ppn, off});
            cnt++;
          end

    // R1: aliasing on the same slot
    refill(mk_va(52'h40, 12'h0), 2'd1, mk_pte(52'hA, 6'b000111, 1), 0, 0, 0);
    refill(mk_va(52'h41, 12'h0), 2'd1, mk_pte(52'hB, 6'b000111, 1), 0, 0, 0);
    refill(mk_va(52'h40 + NE, 12'h0), 2'd1, mk_pte(52'hC, 6'b000111, 1), 0, 0, 0);
    idle();
    look(mk_va(52'h40, 12'h10), 2'd1);
    check(lk_miss, "R1 evicted alias", {63'd0, lk_miss}, 64'd1);
    look(mk_va(52'h40 + NE, 12'h10), 2'd1);
    check(lk_hit && lk_pa == {52'hC, 12'h10}, "R1 alias hit", lk_pa, {52'hC, 12'h10});
    look(mk_va(52'h41, 12'h0), 2'd0);
    check(lk_hit && lk_pa == {52'hB, 12'h0}, "R1 neighbour slot", lk_pa, {52'hB, 12'h0});

    // R10: kind 3 treated as load
    refill(mk_va(52'h42, 12'h0), 2'd3, mk_pte(52'hD, 6'b000100, 1), 0, 0, 0);
    check(!rf_fault && rf_fkind == 2'd1, "R6 kind3 as load", {62'd0, rf_fkind}, 64'd1);
    idle();
    look(mk_va(52'h42, 12'h0), 2'd3);
    check(lk_hits == 3'b010 && lk_hit, "R10 kind3 lookup", {61'd0, lk_hits}, 64'd2);

    // R8: no-cache refill leaves state alone
    refill(mk_va(52'h43, 12'h0), 2'd1, mk_pte(52'hE, 6'b000111, 1), 0, 0, 0);
    refill(mk_va(52'h43 + NE, 12'h55), 2'd1, mk_pte(52'hF, 6'b000111, 1), 0, 1, 0);
    check(!rf_fault && rf_pa == {52'hF, 12'h55}, "R8 nocache paddr", rf_pa, {52'hF, 12'h55});
    idle();
    look(mk_va(52'h43, 12'h0), 2'd1);
    check(lk_hits == 3'b111 && lk_pa == {52'hE, 12'h0}, "R8 kept entry", lk_pa, {52'hE, 12'h0});
    look(mk_va(52'h43 + NE, 12'h0), 2'd1);
    check(lk_hits == 3'b000, "R8 not installed", {61'd0, lk_hits}, 64'd0);

    // R2: flush empties everything
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    for (int v = 0; v < NE; v++) begin
      look(mk_va(52'h40 + 52'(v), 12'h0), 2'd1);
      check(lk_hits == 3'b000, "R2 flush empties", {61'd0, lk_hits}, 64'd0);
    end

    // R9: flush and refill together
    refill(mk_va(52'h44, 12'h0), 2'd0, mk_pte(52'h9, 6'b000111, 1), 0, 0, 1);
    idle();
    look(mk_va(52'h44, 12'h0), 2'd0);
    check(lk_hits == 3'b000, "R9 flush wins", {61'd0, lk_hits}, 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule